// File: doc/BRIEF.md
# Peripheral Pin Router

This block sits between one group of eight I/O pads and a set of on-chip peripherals: two-wire serial bus controllers, synchronous serial controllers, asynchronous serial controllers and 16-bit timers, each with several channels. Software picks, separately for every pad, a peripheral type, a channel of that type and one signal of that channel. The block then connects the peripheral's output value and drive enable to that pad, and connects the pad's input value back to the peripheral.

Each pad's choice is held in an 8-bit field, and two fields share one 16-bit setting register, so register k configures pads 2k and 2k+1. Every peripheral signal occupies a "slot" in a flat signal vector. Peripherals drive `sig_out`/`sig_oe` per slot and read `sig_in` per slot. Each pad has a single enable input that says whether the external general-purpose I/O logic has handed the pad to the peripheral function. The block is purely combinational from register state to pads, except for the register file.

Top module: `pinmux_top`

## Requirements
- R1: After reset every setting register reads 0, and no pad drives (`pad_oe` = 0) even with all pad enables high.
- R2: A write to register address k stores `reg_wdata`, which reads back unchanged at that address. The even pad 2k uses bits 2:0 for peripheral type, bits 4:3 for channel and bits 7:5 for signal. The odd pad 2k+1 uses the same layout in bits 10:8, 12:11 and 15:13.
- R3: Type codes are 1 = two-wire bus, 2 = synchronous serial, 3 = asynchronous serial and 4 = timer. The legal signal codes are as follows. Two-wire bus: 1 clock, 2 data. Synchronous serial: 1 data in, 2 data out, 3 clock, 4 select. Asynchronous serial: 1 receive, 2 transmit. Timer: 1 to 4 for lines 0 to 3. A legal choice selects slot base + channel × signals-per-type + (signal − 1), where the bases are 0, 6, 18 and 24 for the types in that order. With the pad enable high, `pad_out`/`pad_oe` then follow `sig_out`/`sig_oe` of that slot.
- R4: Type 0 or signal 0 means the pad is unassigned. With its enable high, such a pad holds `pad_oe` = 0 and `pad_out` = 0.
- R5: With its enable low, a pad holds `pad_oe` = 0 and `pad_out` = 0, whatever its setting.
- R6: A pad routed to a two-wire bus slot is open-drain: `pad_out` is 0 and `pad_oe` follows that slot's `sig_oe` (the drive-low request), and `sig_out` is ignored.
- R7: One output slot may feed several pads at once, and each of those pads carries it.
- R8: Each slot's `sig_in` takes `pad_in` of an enabled pad whose legal setting selects that slot.
- R9: If several enabled pads select the same slot, the lowest-numbered one supplies `sig_in`.
- R10: A slot that no enabled pad selects receives its idle level on `sig_in`. The idle level is 1 for both two-wire bus lines, synchronous serial select and asynchronous receive, and 0 for every other slot. With the defaults this is 32'h0056223F.
- R11: Reserved codes are stored and read back as written, but route nothing (`pad_oe` = 0, `pad_out` = 0). The reserved codes are type 5 to 7, a channel at or above the type's channel count (3, 3, 3, 2), or a signal beyond the type's list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 2 | Setting register index |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| port_en | input | 8 | Per-pad peripheral-function enable |
| pad_in | input | 8 | Pad input values |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad drive enables |
| sig_out | input | 32 | Peripheral output value per slot |
| sig_oe | input | 32 | Peripheral drive enable per slot |
| sig_in | output | 32 | Peripheral input value per slot |

## Verification
The bench builds the block with its default parameters: eight pads, four registers, and channel counts of 3, 3, 3 and 2. This gives 32 slots, so the 5-bit slot index is fully used. The top slot (timer channel 1, line 3) and the first out-of-range channel (timer channel 2) can both be reached from ordinary register writes. With these values, one pad pair exercises open-drain lanes, shared outputs and reserved codes. Routing contention on a single input slot is driven from two pads in the third register.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

    typedef enum logic [2:0] {
        PER_NONE = 3'd0,
        PER_TWB  = 3'd1,
        PER_SSP  = 3'd2,
        PER_ASP  = 3'd3,
        PER_TMR  = 3'd4
    } periph_e;

    typedef struct packed {
        logic [2:0] fn;
        logic [1:0] ch;
        periph_e    sel;
    } port_cfg_t;

    localparam int FN_TWB = 2;
    localparam int FN_SSP = 4;
    localparam int FN_ASP = 2;
    localparam int FN_TMR = 4;

    function automatic logic fits(logic [1:0] ch, logic [2:0] fn, int nch, int nfn);
        return (int'(ch) < nch) && (fn != 3'd0) && (int'(fn) <= nfn);
    endfunction

    // Idle level for every slot; sized for the largest channel counts the 2-bit field allows.
    function automatic logic [63:0] idle_levels(int n_twb, int n_ssp, int n_asp);
        logic [63:0] v;
        int b;
        v = '0;
        for (int c = 0; c < n_twb; c++) begin
            v[c*FN_TWB]     = 1'b1;
            v[c*FN_TWB + 1] = 1'b1;
        end
        b = n_twb * FN_TWB;
        for (int c = 0; c < n_ssp; c++) v[b + c*FN_SSP + 3] = 1'b1;
        b = b + n_ssp * FN_SSP;
        for (int c = 0; c < n_asp; c++) v[b + c*FN_ASP] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs #(
    parameter int NR = 4,
    parameter int AW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    reg_addr,
    input  logic             reg_wr,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    output logic [NR*16-1:0] cfg_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (reg_wr && (int'(reg_addr) < NR)) begin
            cfg_q[int'(reg_addr)*16 +: 16] <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (int'(reg_addr) < NR) reg_rdata = cfg_q[int'(reg_addr)*16 +: 16];
    end

endmodule

// File: rtl/pinmux_decode.sv
module pinmux_decode
    import pinmux_pkg::*;
#(
    parameter int N_TWB = 3,
    parameter int N_SSP = 3,
    parameter int N_ASP = 3,
    parameter int N_TMR = 2,
    parameter int SW    = 5
) (
    input  port_cfg_t        cfg,
    output logic             hit,
    output logic [SW-1:0]    slot,
    output logic             open_drain
);

    localparam int B_TWB = 0;
    localparam int B_SSP = B_TWB + N_TWB * FN_TWB;
    localparam int B_ASP = B_SSP + N_SSP * FN_SSP;
    localparam int B_TMR = B_ASP + N_ASP * FN_ASP;

    always_comb begin
        hit        = 1'b0;
        slot       = '0;
        open_drain = 1'b0;
        case (cfg.sel)
            PER_TWB: if (fits(cfg.ch, cfg.fn, N_TWB, FN_TWB)) begin
                hit        = 1'b1;
                slot       = SW'(B_TWB + int'(cfg.ch) * FN_TWB + int'(cfg.fn) - 1);
                open_drain = 1'b1;
            end
            PER_SSP: if (fits(cfg.ch, cfg.fn, N_SSP, FN_SSP)) begin
                hit  = 1'b1;
                slot = SW'(B_SSP + int'(cfg.ch) * FN_SSP + int'(cfg.fn) - 1);
            end
            PER_ASP: if (fits(cfg.ch, cfg.fn, N_ASP, FN_ASP)) begin
                hit  = 1'b1;
                slot = SW'(B_ASP + int'(cfg.ch) * FN_ASP + int'(cfg.fn) - 1);
            end
            PER_TMR: if (fits(cfg.ch, cfg.fn, N_TMR, FN_TMR)) begin
                hit  = 1'b1;
                slot = SW'(B_TMR + int'(cfg.ch) * FN_TMR + int'(cfg.fn) - 1);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pinmux_inroute.sv
module pinmux_inroute #(
    parameter int NP = 8,
    parameter int NS = 32,
    parameter int SW = 5,
    parameter logic [NS-1:0] IDLE = '0
) (
    input  logic [NP-1:0]    port_en,
    input  logic [NP-1:0]    pad_in,
    input  logic [NP-1:0]    hit,
    input  logic [NP*SW-1:0] slot_flat,
    output logic [NS-1:0]    sig_in
);

    for (genvar s = 0; s < NS; s++) begin : g_slot
        logic v;
        always_comb begin
            v = IDLE[s];
            // scanning downwards lets the lowest matching pad win
            for (int p = NP - 1; p >= 0; p--) begin
                if (port_en[p] && hit[p] && (slot_flat[p*SW +: SW] == SW'(s))) v = pad_in[p];
            end
        end
        assign sig_in[s] = v;
    end

endmodule

// File: rtl/pinmux_top.sv
module pinmux_top
    import pinmux_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int N_TWB     = 3,
    parameter int N_SSP     = 3,
    parameter int N_ASP     = 3,
    parameter int N_TMR     = 2,
    localparam int NUM_REGS  = NUM_PORTS / 2,
    localparam int AW        = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int NUM_SLOTS = N_TWB*FN_TWB + N_SSP*FN_SSP + N_ASP*FN_ASP + N_TMR*FN_TMR,
    localparam int SW        = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        reg_addr,
    input  logic                 reg_wr,
    input  logic [15:0]          reg_wdata,
    output logic [15:0]          reg_rdata,
    input  logic [NUM_PORTS-1:0] port_en,
    input  logic [NUM_PORTS-1:0] pad_in,
    output logic [NUM_PORTS-1:0] pad_out,
    output logic [NUM_PORTS-1:0] pad_oe,
    input  logic [NUM_SLOTS-1:0] sig_out,
    input  logic [NUM_SLOTS-1:0] sig_oe,
    output logic [NUM_SLOTS-1:0] sig_in
);

    localparam logic [63:0] IDLE_ALL = idle_levels(N_TWB, N_SSP, N_ASP);
    localparam logic [NUM_SLOTS-1:0] IDLE = IDLE_ALL[NUM_SLOTS-1:0];

    logic [NUM_REGS*16-1:0]   cfg_flat;
    logic [NUM_PORTS-1:0]     hit;
    logic [NUM_PORTS-1:0]     od;
    logic [NUM_PORTS*SW-1:0]  slot_flat;

    pinmux_regs #(.NR(NUM_REGS), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg_q     (cfg_flat)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        port_cfg_t       pcfg;
        logic [SW-1:0]   pslot;

        assign pcfg = port_cfg_t'(cfg_flat[p*8 +: 8]);

        pinmux_decode #(
            .N_TWB(N_TWB), .N_SSP(N_SSP), .N_ASP(N_ASP), .N_TMR(N_TMR), .SW(SW)
        ) u_dec (
            .cfg        (pcfg),
            .hit        (hit[p]),
            .slot       (pslot),
            .open_drain (od[p])
        );

        assign slot_flat[p*SW +: SW] = pslot;

        always_comb begin
            pad_out[p] = 1'b0;
            pad_oe[p]  = 1'b0;
            if (port_en[p] && hit[p]) begin
                pad_oe[p] = sig_oe[pslot];
                if (!od[p]) pad_out[p] = sig_out[pslot];
            end
        end
    end

    pinmux_inroute #(
        .NP(NUM_PORTS), .NS(NUM_SLOTS), .SW(SW), .IDLE(IDLE)
    ) u_in (
        .port_en   (port_en),
        .pad_in    (pad_in),
        .hit       (hit),
        .slot_flat (slot_flat),
        .sig_in    (sig_in)
    );

endmodule

// File: rtl/pinmux_chk.sv
module pinmux_chk #(
    parameter int NP = 8,
    parameter int NS = 32,
    parameter int AW = 2,
    parameter int NR = 4,
    parameter logic [NS-1:0] IDLE = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    reg_addr,
    input logic             reg_wr,
    input logic [15:0]      reg_wdata,
    input logic [15:0]      reg_rdata,
    input logic [NP-1:0]    port_en,
    input logic [NP-1:0]    pad_out,
    input logic [NP-1:0]    pad_oe,
    input logic [NS-1:0]    sig_in,
    input logic [NR*16-1:0] cfg_flat
);

    // R2
    wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_addr != $past(reg_addr)) || (reg_rdata == $past(reg_wdata)));

    // R10
    idle_when_unrouted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_en == '0) |-> (sig_in == IDLE));

    for (genvar p = 0; p < NP; p++) begin : g_chk
        // R5
        port_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !port_en[p] |-> (!pad_oe[p] && !pad_out[p]));

        // R4
        no_sel_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_flat[p*8 +: 3] == 3'd0) |-> (!pad_oe[p] && !pad_out[p]));

        // R6
        open_drain_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_flat[p*8 +: 3] == 3'd1) |-> !pad_out[p]);
    end

endmodule

bind pinmux_top pinmux_chk #(
    .NP(NUM_PORTS), .NS(NUM_SLOTS), .AW(AW), .NR(NUM_REGS), .IDLE(IDLE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .port_en   (port_en),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .sig_in    (sig_in),
    .cfg_flat  (cfg_flat)
);

// File: tb/sim_pinmux_top.sv
module sim_pinmux_top;

    localparam int PERIOD = 10;
    localparam logic [31:0] IDLE = 32'h0056_223F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  port_en = '0;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out;
    logic [7:0]  pad_oe;
    logic [31:0] sig_out = '0;
    logic [31:0] sig_oe = '0;
    logic [31:0] sig_in;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    pinmux_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .port_en(port_en),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .sig_out(sig_out), .sig_oe(sig_oe), .sig_in(sig_in)
    );

    // {setting, sig_out, sig_oe, expected pad_out[1:0], expected pad_oe[1:0]}
    localparam logic [83:0] VEC [8] = '{
        {16'h534A, 32'h0000_0800, 32'h0080_0800, 2'b01, 2'b11}, // R3 data out + transmit
        {16'h534A, 32'h0080_0000, 32'h0080_0000, 2'b10, 2'b10}, // R3 per-slot oe
        {16'h008C, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b01, 2'b01}, // R3 top slot, R4 odd none
        {16'h3425, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00, 2'b00}, // R11 type 5, timer ch2
        {16'h5121, 32'hFFFF_FFFF, 32'h0000_0001, 2'b00, 2'b01}, // R6 open drain
        {16'h6262, 32'h0000_0100, 32'h0000_0100, 2'b11, 2'b11}, // R7 shared clock
        {16'h0361, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00, 2'b00}, // R11 signal 3, R4 signal 0
        {16'h39A2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00, 2'b00}  // R11 signal 5, channel 3
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n   = 1'b1;
        port_en = 8'hFF;
        @(negedge clk);

        // R1: registers clear, nothing drives
        for (int r = 0; r < 4; r++) begin
            reg_addr = 2'(r);
            #1;
            chk(reg_rdata == 16'h0, "R1 reset readback", {16'h0, reg_rdata}, 32'h0);
        end
        chk(pad_oe == 8'h00, "R1/R4 reset oe", {24'h0, pad_oe}, 32'h0);
        // R10: all slots idle
        chk(sig_in == IDLE, "R10 idle levels", sig_in, IDLE);

        // table walk over pads 0 and 1
        for (int i = 0; i < 8; i++) begin
            wr(2'd0, VEC[i][83:68]);
            sig_out = VEC[i][67:36];
            sig_oe  = VEC[i][35:4];
            reg_addr = 2'd0;
            #1;
            chk(reg_rdata == VEC[i][83:68], "R2/R11 readback", {16'h0, reg_rdata}, {16'h0, VEC[i][83:68]});
            chk(pad_out[1:0] == VEC[i][3:2], "R3/R6/R7/R11 pad_out", {30'h0, pad_out[1:0]}, {30'h0, VEC[i][3:2]});
            chk(pad_oe[1:0] == VEC[i][1:0], "R3/R4/R6/R11 pad_oe", {30'h0, pad_oe[1:0]}, {30'h0, VEC[i][1:0]});
        end

        // R5: enable low silences routed pads
        wr(2'd0, 16'h534A);
        sig_out = 32'hFFFF_FFFF;
        sig_oe  = 32'hFFFF_FFFF;
        port_en = 8'h00;
        #1;
        chk(pad_oe == 8'h00 && pad_out == 8'h00, "R5 disabled pads", {16'h0, pad_oe, pad_out}, 32'h0);
        port_en = 8'hFF;

        // R2: odd/even field positions in register 3 (pads 6,7)
        wr(2'd0, 16'h0000);
        wr(2'd3, 16'h6200);
        sig_out = 32'h0000_0100;
        sig_oe  = 32'h0000_0100;
        #1;
        chk(pad_oe == 8'h80 && pad_out == 8'h80, "R2 odd field", {16'h0, pad_oe, pad_out}, 32'h8080);
        wr(2'd3, 16'h0062);
        #1;
        chk(pad_oe == 8'h40 && pad_out == 8'h40, "R2 even field", {16'h0, pad_oe, pad_out}, 32'h4040);
        reg_addr = 2'd0;
        #1;
        chk(reg_rdata == 16'h0000, "R2 other register untouched", {16'h0, reg_rdata}, 32'h0);
        wr(2'd3, 16'h0000);

        // R8: receive on pad 2, timer capture on pad 3
        wr(2'd1, 16'h4423);
        pad_in = 8'b0000_1000;
        #1;
        chk(sig_in == 32'h0252_223F, "R8 input routing", sig_in, 32'h0252_223F);
        pad_in = 8'b0000_0100;
        #1;
        chk(sig_in == 32'h0056_223F, "R8 input follows pad", sig_in, 32'h0056_223F);
        wr(2'd1, 16'h0000);

        // R9: pads 4 and 5 both on sync serial ch2 data in (slot 14)
        wr(2'd2, 16'h3232);
        pad_in = 8'b0001_0000;
        #1;
        chk(sig_in[14] == 1'b1, "R9 lowest pad wins (1)", {31'h0, sig_in[14]}, 32'h1);
        pad_in = 8'b0010_0000;
        #1;
        chk(sig_in[14] == 1'b0, "R9 lowest pad wins (0)", {31'h0, sig_in[14]}, 32'h0);
        port_en = 8'b1110_1111;
        #1;
        chk(sig_in[14] == 1'b1, "R8/R9 disabled pad skipped", {31'h0, sig_in[14]}, 32'h1);
        port_en = 8'h00;
        #1;
        chk(sig_in == IDLE, "R10 idle with pads disabled", sig_in, IDLE);

        finish_run();
    end

endmodule